// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial port from the system clock. The division happens in two stages. The first stage divides by an even prescale value of up to 254. The second stage multiplies the period by a rate factor from 1 to 256. The serial clock period is therefore prescale × (1 + rate) system cycles. Each period is made of two halves of equal length. The clock leaves its idle level at the end of the first half and returns to it at the end of the second.

Both divisor fields are written through a small write port and can be read back at any time. The values that actually drive the counters are copied from those registers only while the port is idle. The same holds for the idle level and the edge-phase choice. A write made in the middle of a frame therefore never disturbs the bit timing. Next to the clock level, the block produces one-cycle strobes that tell a shifter when to launch a bit and when to capture one.

Top module: `serial_rate_divider`

## Requirements
- R1: While reset is held and after it is released, both divisor readbacks are zero and neither strobe is high.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata` into the prescale register with bit 0 forced to zero. A write with `cfg_sel`=1 stores all bits into the rate register. Either readback shows the new value from the cycle after the write edge.
- R3: While running, each half of the serial clock lasts (P/2)·(1+S) system cycles. P is the active prescale and S is the active rate. The first change away from idle comes after that many rising edges with `run` high.
- R4: An active prescale of zero divides like a prescale of 2, so the clock keeps running after reset.
- R5: A strobe is high for exactly the cycle in which `sclk` first shows its new level. The edge leaving idle is the leading edge and the edge returning to idle is the trailing edge. With phase 0, `capture_stb` marks leading edges and `launch_stb` marks trailing edges. With phase 1 the roles are swapped. The two strobes are never high together.
- R6: On any clock edge with `run` low, the counters reload. After that edge, `sclk` equals the `cpol` sampled at that edge and both strobes are low. Restarting from there gives a full first half again.
- R7: Divisor writes made while `run` is high take effect only after `run` has been low for one edge. Until then the running timing keeps the old values.
- R8: `cpol` and `cpha` are sampled only while idle. Changing them while running does not alter which strobe fires.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for a divisor field |
| cfg_sel | input | 1 | Field select: 0 prescale, 1 rate |
| cfg_wdata | input | DW (8) | Write data |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Edge phase: 0 capture on leading, 1 capture on trailing |
| run | input | 1 | Port enabled and frame in progress |
| prescale_q | output | DW (8) | Prescale readback (bit 0 always 0) |
| rate_q | output | DW (8) | Rate readback |
| sclk | output | 1 | Serial clock level |
| capture_stb | output | 1 | One-cycle strobe at a capture edge |
| launch_stb | output | 1 | One-cycle strobe at a launch edge |

## Verification
The bench goes after the divisor extremes and the cases that break them:
- a half-period of a single cycle;
- a prescale of zero, and an odd prescale write;
- the largest product, 254 × 256.

A design that ignored the forced LSB or treated zero literally would measure wrong half lengths or stall. A design that used the live register values would change period when a divisor is written mid-frame, and the bench catches that. It also drops `run` halfway through a half and toggles `cpol` while running. An implementation that kept its counters, or read the polarity live, would show a short first half or the wrong strobe.

// File: rtl/srd_pkg.sv
package srd_pkg;

  // Even prescale value after the zero guard; input is already even.
  function automatic int eff_prescale(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  // System cycles counted by the first stage per tick.
  function automatic int prescale_half(input int p);
    return eff_prescale(p) / 2;
  endfunction

  // System cycles in one half of the serial clock.
  function automatic int half_cycles(input int p, input int s);
    return prescale_half(p) * (s + 1);
  endfunction

endpackage

// File: rtl/srd_cfg_regs.sv
module srd_cfg_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          run,
  input  logic          cpol,
  input  logic          cpha,
  output logic [DW-1:0] pre_q,
  output logic [DW-1:0] rate_q,
  output logic [DW-1:0] act_pre,
  output logic [DW-1:0] act_rate,
  output logic          act_cpol,
  output logic          act_cpha
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (cfg_wr) begin
      if (!cfg_sel) pre_q  <= {cfg_wdata[DW-1:1], 1'b0};
      else          rate_q <= cfg_wdata;
    end
  end

  // Shadow copy: follows the registers only while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pre  <= '0;
      act_rate <= '0;
      act_cpol <= 1'b0;
      act_cpha <= 1'b0;
    end else if (!run) begin
      act_pre  <= pre_q;
      act_rate <= rate_q;
      act_cpol <= cpol;
      act_cpha <= cpha;
    end
  end

  assert_pre_even_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel) |=> (pre_q == {$past(cfg_wdata[DW-1:1]), 1'b0}));

  assert_rate_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel) |=> (rate_q == $past(cfg_wdata)));

  assert_shadow_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(act_pre) && $stable(act_rate) && $stable(act_cpol) && $stable(act_cpha)));

endmodule

// File: rtl/srd_prescale_stage.sv
module srd_prescale_stage #(
  parameter int DW = 8,
  localparam int CW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half_div,
  output logic          tick
);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == half_div - CW'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (at_end)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  assert_pre_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half_div));

  assert_pre_cnt_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/srd_rate_stage.sv
module srd_rate_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] rate,
  output logic          half_end
);

  logic [DW-1:0] cnt_q;

  assign half_end = tick && (cnt_q == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (half_end) cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + DW'(1);
  end

  assert_rate_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= rate));

  assert_rate_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/srd_edge_gen.sv
module srd_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic half_end,
  input  logic act_cpol,
  input  logic act_cpha,
  output logic sclk,
  output logic capture_stb,
  output logic launch_stb
);

  logic active_q;
  logic lead_edge;
  logic trail_edge;

  assign lead_edge  = run && half_end && !active_q;
  assign trail_edge = run && half_end &&  active_q;
  assign sclk       = active_q ^ act_cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      capture_stb <= 1'b0;
      launch_stb  <= 1'b0;
    end else begin
      if (!run)          active_q <= 1'b0;
      else if (half_end) active_q <= ~active_q;
      capture_stb <= act_cpha ? trail_edge : lead_edge;
      launch_stb  <= act_cpha ? lead_edge  : trail_edge;
    end
  end

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({capture_stb, launch_stb}));

  assert_strobe_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (capture_stb || launch_stb)) |-> (sclk != $past(sclk)));

  assert_toggle_marked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_end) |=> (capture_stb || launch_stb));

endmodule

// File: rtl/serial_rate_divider.sv
module serial_rate_divider #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          run,
  output logic [DW-1:0] prescale_q,
  output logic [DW-1:0] rate_q,
  output logic          sclk,
  output logic          capture_stb,
  output logic          launch_stb
);

  localparam int HW = DW - 1;

  logic [DW-1:0] act_pre;
  logic [DW-1:0] act_rate;
  logic          act_cpol;
  logic          act_cpha;
  logic [HW-1:0] pre_half;
  logic          pre_tick;
  logic          half_end;

  srd_cfg_regs #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .run(run), .cpol(cpol), .cpha(cpha),
    .pre_q(prescale_q), .rate_q(rate_q), .act_pre(act_pre),
    .act_rate(act_rate), .act_cpol(act_cpol), .act_cpha(act_cpha)
  );

  assign pre_half = HW'(srd_pkg::prescale_half(int'(act_pre)));

  srd_prescale_stage #(.DW(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .half_div(pre_half), .tick(pre_tick)
  );

  srd_rate_stage #(.DW(DW)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(pre_tick),
    .rate(act_rate), .half_end(half_end)
  );

  srd_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .half_end(half_end),
    .act_cpol(act_cpol), .act_cpha(act_cpha), .sclk(sclk),
    .capture_stb(capture_stb), .launch_stb(launch_stb)
  );

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((sclk == $past(cpol)) && !capture_stb && !launch_stb));

  assert_zero_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_half != '0);

endmodule

// File: tb/serial_rate_divider_bench.sv
module serial_rate_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int LIMIT      = 40000;
  localparam int NVEC       = 7;
  // prescale write, rate write, cpol, cpha
  localparam int VEC [0:NVEC-1][0:3] = '{
    '{0,   0,  0, 0},
    '{2,   0,  1, 0},
    '{3,   2,  0, 1},
    '{10,  0,  0, 0},
    '{7,   4,  1, 1},
    '{254, 1,  0, 0},
    '{16,  15, 1, 0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          cpol = 1'b0;
  logic          cpha = 1'b0;
  logic          run = 1'b0;
  logic [DW-1:0] prescale_q;
  logic [DW-1:0] rate_q;
  logic          sclk;
  logic          capture_stb;
  logic          launch_stb;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rate_divider #(.DW(DW)) u_serial_rate_divider (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpol(cpol), .cpha(cpha), .run(run),
    .prescale_q(prescale_q), .rate_q(rate_q), .sclk(sclk),
    .capture_stb(capture_stb), .launch_stb(launch_stb)
  );

  function automatic int exp_half(input int p, input int s);
    int ev;
    ev = p & 254;
    if (ev == 0) ev = 2;
    return (ev / 2) * (s + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit sel, input int val);
    cfg_wr    = 1'b1;
    cfg_sel   = sel;
    cfg_wdata = DW'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_toggle(output int n);
    logic prev;
    prev = sclk;
    n = 0;
    while (1) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      n++;
      if (sclk != prev || n >= LIMIT) break;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int h;
    // R1: reset state
    idle_cycles(2);
    check(prescale_q == 0, "R1 prescale reset", int'(prescale_q), 0);
    check(rate_q == 0, "R1 rate reset", int'(rate_q), 0);
    check(!capture_stb && !launch_stb, "R1 strobes reset", int'({capture_stb, launch_stb}), 0);
    rst_n = 1'b1;
    idle_cycles(2);
    check(prescale_q == 0 && rate_q == 0, "R1 after release", int'(prescale_q), 0);
    check(sclk == cpol, "R6 idle level after reset", int'(sclk), int'(cpol));

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      h = exp_half(VEC[v][0], VEC[v][1]);
      write_cfg(1'b0, VEC[v][0]);
      write_cfg(1'b1, VEC[v][1]);
      cpol = VEC[v][2][0];
      cpha = VEC[v][3][0];
      idle_cycles(2);
      check(prescale_q == DW'(VEC[v][0] & 254), "R2 prescale readback", int'(prescale_q), VEC[v][0] & 254);
      check(rate_q == DW'(VEC[v][1]), "R2 rate readback", int'(rate_q), VEC[v][1]);
      check(sclk == cpol, "R6 idle level", int'(sclk), int'(cpol));
      run = 1'b1;
      wait_toggle(n);
      check(n == h, "R3 first half length", n, h);
      check(sclk != cpol, "R3 left idle", int'(sclk), int'(!cpol));
      check(capture_stb == !cpha && launch_stb == cpha, "R5 leading strobe",
            int'({capture_stb, launch_stb}), int'({!cpha, cpha}));
      wait_toggle(n);
      check(n == h, "R3 second half length", n, h);
      check(capture_stb == cpha && launch_stb == !cpha, "R5 trailing strobe",
            int'({capture_stb, launch_stb}), int'({cpha, !cpha}));
      if (h > 1) begin
        @(negedge clk);
        check(!capture_stb && !launch_stb, "R5 strobe single cycle",
              int'({capture_stb, launch_stb}), 0);
      end
      run = 1'b0;
      idle_cycles(1);
    end

    // R4: odd write of 1 reads 0 and divides like 2
    cpol = 1'b0; cpha = 1'b0;
    write_cfg(1'b0, 1);
    write_cfg(1'b1, 0);
    idle_cycles(2);
    check(prescale_q == 0, "R4 odd one reads zero", int'(prescale_q), 0);
    run = 1'b1;
    wait_toggle(n);
    check(n == 1, "R4 zero prescale divides by two", n, 1);
    run = 1'b0;
    idle_cycles(2);

    // R7: write during run keeps old timing
    write_cfg(1'b0, 4);
    idle_cycles(2);
    run = 1'b1;
    wait_toggle(n);
    check(n == 2, "R7 baseline half", n, 2);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = DW'(20);
    wait_toggle(n);
    check(n == 2, "R7 old timing kept", n, 2);
    check(prescale_q == 20, "R7 readback updated", int'(prescale_q), 20);
    wait_toggle(n);
    check(n == 2, "R7 old timing still kept", n, 2);
    run = 1'b0;
    idle_cycles(1);
    run = 1'b1;
    wait_toggle(n);
    check(n == 10, "R7 new timing after idle", n, 10);
    run = 1'b0;
    idle_cycles(2);

    // R6: drop run mid-half, then restart with a full half
    write_cfg(1'b0, 10);
    idle_cycles(2);
    run = 1'b1;
    wait_toggle(n);
    idle_cycles(2);
    run = 1'b0;
    @(negedge clk);
    check(sclk == cpol, "R6 back to idle on disable", int'(sclk), int'(cpol));
    check(!capture_stb && !launch_stb, "R6 no strobe on disable",
          int'({capture_stb, launch_stb}), 0);
    run = 1'b1;
    idle_cycles(3);
    check(sclk == cpol, "R6 counters reloaded", int'(sclk), int'(cpol));
    wait_toggle(n);
    check(n == 2, "R6 full half after restart", n, 2);
    run = 1'b0;
    idle_cycles(2);

    // R8: cpol change while running is ignored
    cpol = 1'b0; cpha = 1'b0;
    idle_cycles(2);
    run = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    wait_toggle(n);
    check(sclk == 1'b1, "R8 level uses sampled cpol", int'(sclk), 1);
    check(capture_stb && !launch_stb, "R8 strobe uses sampled cpol",
          int'({capture_stb, launch_stb}), 2);
    run = 1'b0;
    cpol = 1'b0;
    idle_cycles(2);

    // R3: largest product
    write_cfg(1'b0, 254);
    write_cfg(1'b1, 255);
    idle_cycles(2);
    run = 1'b1;
    wait_toggle(n);
    check(n == exp_half(254, 255), "R3 largest divisor", n, exp_half(254, 255));
    run = 1'b0;
    idle_cycles(2);

    finish_run();
  end

endmodule